// File: doc/BRIEF.md
# Flash Rewrite Control Register

This block is the guard register that sits between a CPU and the control logic of an on-chip flash array. Software uses it to enter and leave the mode in which the flash may be programmed and erased, to override block lock protection during erase, to hold the flash control logic in reset, and to choose between the boot area and the user area when the device has started in boot mode. The register also reports whether the flash engine is ready or busy.

The two bits that open protected paths (rewrite mode and lock override) are never set by a single store. Each one needs a pair of register writes on consecutive clock cycles: the first with the bit at 0, the second identical to the first except that the bit is now 1. The rewrite-mode pair is accepted only while the NMI pin is high, and the lock override pair only while rewrite mode is already on. Clearing either bit takes one write of 0.

A second port carries software command writes towards the flash command decoder. The block forwards a command, one cycle later, only when its address is even and rewrite mode is active. Odd-address writes and writes outside rewrite mode are dropped.

Top module: `flash_rewrite_ctl`

## Requirements
- R1: After reset, rewrite mode, lock override, flash reset and the area select bit are all 0, no command strobe is issued, and with the engine idle the register reads 0x01.
- R2: Register bit 0 reads 0 while `busy_i` is 1 and 1 otherwise; writing bit 0 changes nothing.
- R3: Rewrite mode (bit 1) becomes 1 only when a register write with bit 1 = 0 is followed in the very next cycle by a write whose value equals the first with bit 1 set, and `nmi_i` is 1 during that second write.
- R4: Any register write with bit 1 = 0 clears rewrite mode and, in the same cycle, clears lock override.
- R5: The set sequence is broken by an idle cycle between the two writes or by a second write that differs from the first in any bit other than the guarded one; the guarded bit then stays unchanged.
- R6: Lock override (bit 2) is set by the same two-write sequence on bit 2, and any write to bit 2 is ignored while rewrite mode is 0; while rewrite mode is 1, writing bit 2 = 0 clears it.
- R7: Writing bit 3 = 1 while rewrite mode is 1 asserts `flash_rst_o`; writing bit 3 = 1 while rewrite mode is 0 has no effect; writing bit 3 = 0 clears it at any time.
- R8: Bit 5 is written directly at any time. `user_area_o` equals bit 5 when `boot_i` is 1 and is 1 when `boot_i` is 0, independent of rewrite mode.
- R9: A command write with address bit 0 = 0 while rewrite mode is 1 produces `cmd_stb_o` = 1 for one cycle on the following cycle, with that address and data on `cmd_addr_o` and `cmd_data_o`; odd addresses or writes while rewrite mode is 0 produce no strobe and leave those outputs unchanged.
- R10: `erase_lock_o` is 1 when lock override is 1 (a locked block, lock flag 0, comes out of erase unlocked); otherwise it equals `erase_lock_i`.
- R11: The register reads back {0, 0, bit 5, 0, flash reset, lock override, rewrite mode, ready}, bit 7 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| nmi_i | input | 1 | NMI pin level |
| boot_i | input | 1 | Boot-mode strap |
| busy_i | input | 1 | Flash engine running a program or erase |
| cmd_wr | input | 1 | Software command write strobe |
| cmd_addr | input | CMD_AW | Command write address |
| cmd_wdata | input | CMD_DW | Command write data |
| cmd_stb_o | output | 1 | Accepted command strobe |
| cmd_addr_o | output | CMD_AW | Address of the last accepted command |
| cmd_data_o | output | CMD_DW | Data of the last accepted command |
| rewrite_o | output | 1 | Rewrite mode active |
| lock_ovr_o | output | 1 | Lock protection override |
| flash_rst_o | output | 1 | Reset to the flash control logic |
| user_area_o | output | 1 | 1 selects the user area, 0 the boot area |
| erase_lock_i | input | 1 | Lock flag of the block being erased, 0 = locked |
| erase_lock_o | output | 1 | Lock flag to store after the erase |

## Verification
The bench attacks the unlock pairs with the NMI pin low, with an idle cycle between the two writes and with a second write that also flips an unrelated bit; a design that only checked the final value of the bit would enter rewrite mode in all three. It tries lock override and flash reset before rewrite mode is on, which a design lacking the gate would accept, and it leaves rewrite mode to see lock override fall with it. Odd-address and out-of-mode command writes catch a filter that looks at the wrong address bit or forgets the mode, and toggling the boot strap exposes an area select that ignores it.

// File: rtl/frc_pkg.sv
package frc_pkg;
    parameter int B_BUSY = 0;
    parameter int B_RW   = 1;
    parameter int B_OVR  = 2;
    parameter int B_FRST = 3;
    parameter int B_USEL = 5;
    parameter int NGUARD = 2;

    typedef struct packed {
        logic rew;
        logic ovr;
        logic frst;
        logic usel;
    } ctl_t;

    function automatic int guard_pos(input int idx);
        return (idx == 0) ? B_RW : B_OVR;
    endfunction
endpackage

// File: rtl/unlock_seq.sv
module unlock_seq #(
    parameter int REG_W = 8,
    parameter int POS   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             gate,
    input  logic             cond,
    output logic             set_o
);
    localparam logic [REG_W-1:0] MASK = REG_W'(1) << POS;

    typedef struct packed {
        logic             armed;
        logic [REG_W-1:0] word;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = wr && gate && !wdata[POS];
        if (wr) begin
            st_d.word = wdata;
        end
        set_o = st_q.armed && wr && gate && cond && (wdata == (st_q.word | MASK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a completing write must directly follow another write
    assert_set_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |-> $past(wr));
endmodule

// File: rtl/cmd_gate.sv
module cmd_gate #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          mode_i,
    output logic          stb_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          stb;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    cmd_t st_d, st_q;
    logic accept;

    always_comb begin
        st_d     = st_q;
        accept   = wr && mode_i && !addr[0];
        st_d.stb = accept;
        if (accept) begin
            st_d.addr = addr;
            st_d.data = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o  = st_q.stb;
    assign addr_o = st_q.addr;
    assign data_o = st_q.data;

    assert_cmd_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> !addr_o[0]);
    assert_cmd_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(mode_i));
endmodule

// File: rtl/flash_rewrite_ctl.sv
module flash_rewrite_ctl
    import frc_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int CMD_AW = 16,
    parameter int CMD_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              nmi_i,
    input  logic              boot_i,
    input  logic              busy_i,
    input  logic              cmd_wr,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [CMD_DW-1:0] cmd_wdata,
    output logic              cmd_stb_o,
    output logic [CMD_AW-1:0] cmd_addr_o,
    output logic [CMD_DW-1:0] cmd_data_o,
    output logic              rewrite_o,
    output logic              lock_ovr_o,
    output logic              flash_rst_o,
    output logic              user_area_o,
    input  logic              erase_lock_i,
    output logic              erase_lock_o
);
    ctl_t st_d, st_q;

    logic [NGUARD-1:0] gate_v;
    logic [NGUARD-1:0] cond_v;
    logic [NGUARD-1:0] set_v;

    assign gate_v[0] = 1'b1;
    assign cond_v[0] = nmi_i;
    assign gate_v[1] = st_q.rew;
    assign cond_v[1] = 1'b1;

    for (genvar g = 0; g < NGUARD; g++) begin : g_guard
        unlock_seq #(
            .REG_W (REG_W),
            .POS   (guard_pos(g))
        ) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr),
            .wdata (reg_wdata),
            .gate  (gate_v[g]),
            .cond  (cond_v[g]),
            .set_o (set_v[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (!reg_wdata[B_RW]) begin
                st_d.rew = 1'b0;
                st_d.ovr = 1'b0;
            end else begin
                if (set_v[0]) begin
                    st_d.rew = 1'b1;
                end
                if (st_q.rew) begin
                    if (!reg_wdata[B_OVR]) begin
                        st_d.ovr = 1'b0;
                    end else if (set_v[1]) begin
                        st_d.ovr = 1'b1;
                    end
                end
            end
            st_d.frst = reg_wdata[B_FRST] ? (st_q.frst | st_q.rew) : 1'b0;
            st_d.usel = reg_wdata[B_USEL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cmd_gate #(
        .AW (CMD_AW),
        .DW (CMD_DW)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmd_wr),
        .addr   (cmd_addr),
        .data   (cmd_wdata),
        .mode_i (st_q.rew),
        .stb_o  (cmd_stb_o),
        .addr_o (cmd_addr_o),
        .data_o (cmd_data_o)
    );

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_BUSY] = !busy_i;
        reg_rdata[B_RW]   = st_q.rew;
        reg_rdata[B_OVR]  = st_q.ovr;
        reg_rdata[B_FRST] = st_q.frst;
        reg_rdata[B_USEL] = st_q.usel;
    end

    assign rewrite_o    = st_q.rew;
    assign lock_ovr_o   = st_q.ovr;
    assign flash_rst_o  = st_q.frst;
    assign user_area_o  = boot_i ? st_q.usel : 1'b1;
    assign erase_lock_o = st_q.ovr | erase_lock_i;

    assert_rw_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rewrite_o) |-> ($past(reg_wr) && $past(nmi_i) && $past(reg_wdata[B_RW])));
    assert_rw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[B_RW]) |=> (!rewrite_o && !lock_ovr_o));
    assert_ovr_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ovr_o |-> rewrite_o);
    assert_frst_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst_o) |-> $past(rewrite_o));
endmodule

// File: tb/flash_rewrite_ctl_test.sv
`timescale 1ns/1ps
module flash_rewrite_ctl_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        nmi_i = 1'b1;
    logic        boot_i = 1'b0;
    logic        busy_i = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_stb_o;
    logic [15:0] cmd_addr_o;
    logic [15:0] cmd_data_o;
    logic        rewrite_o, lock_ovr_o, flash_rst_o, user_area_o;
    logic        erase_lock_i = 1'b0;
    logic        erase_lock_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #HALF clk = ~clk;

    flash_rewrite_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nmi_i(nmi_i), .boot_i(boot_i), .busy_i(busy_i),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_stb_o(cmd_stb_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
        .rewrite_o(rewrite_o), .lock_ovr_o(lock_ovr_o), .flash_rst_o(flash_rst_o),
        .user_area_o(user_area_o), .erase_lock_i(erase_lock_i), .erase_lock_o(erase_lock_o)
    );

    // behavioural reference model
    bit       m_rew = 0, m_ovr = 0, m_frst = 0, m_usel = 0;
    bit       m_arm1 = 0, m_arm2 = 0;
    bit [7:0] m_prev = 0;
    bit       m_stb = 0;
    bit [15:0] m_caddr = 0, m_cdata = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rew = 0; m_ovr = 0; m_frst = 0; m_usel = 0;
            m_arm1 = 0; m_arm2 = 0; m_prev = 0;
            m_stb = 0; m_caddr = 0; m_cdata = 0;
        end else begin
            bit s1, s2, a1, a2;
            m_stb = cmd_wr && !cmd_addr[0] && m_rew;
            if (m_stb) begin
                m_caddr = cmd_addr;
                m_cdata = cmd_wdata;
            end
            s1 = m_arm1 && reg_wr && nmi_i && (reg_wdata == (m_prev | 8'h02));
            s2 = m_arm2 && reg_wr && m_rew && (reg_wdata == (m_prev | 8'h04));
            a1 = reg_wr && !reg_wdata[1];
            a2 = reg_wr && m_rew && !reg_wdata[2];
            if (reg_wr) begin
                bit old_rew;
                old_rew = m_rew;
                if (!reg_wdata[1]) begin
                    m_rew = 0; m_ovr = 0;
                end else begin
                    if (s1) m_rew = 1;
                    if (old_rew) begin
                        if (!reg_wdata[2]) m_ovr = 0;
                        else if (s2) m_ovr = 1;
                    end
                end
                if (reg_wdata[3]) begin
                    if (old_rew) m_frst = 1;
                end else begin
                    m_frst = 0;
                end
                m_usel = reg_wdata[5];
                m_prev = reg_wdata;
            end
            m_arm1 = a1;
            m_arm2 = a2;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R11 R2 rdata", reg_rdata, {2'b00, m_usel, 1'b0, m_frst, m_ovr, m_rew, !busy_i});
            chk("R3 R4 rewrite", rewrite_o, m_rew);
            chk("R6 lock_ovr", lock_ovr_o, m_ovr);
            chk("R7 flash_rst", flash_rst_o, m_frst);
            chk("R8 user_area", user_area_o, boot_i ? m_usel : 1'b1);
            chk("R10 erase_lock", erase_lock_o, m_ovr ? 1'b1 : erase_lock_i);
            chk("R9 cmd_stb", cmd_stb_o, m_stb);
            chk("R9 cmd_addr", cmd_addr_o, m_caddr);
            chk("R9 cmd_data", cmd_data_o, m_cdata);
        end
    end

    task automatic drv(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic cmd(input logic [15:0] a, input logic [15:0] d);
        cmd_wr = 1'b1;
        cmd_addr = a;
        cmd_wdata = d;
        @(posedge clk); #1;
        cmd_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk);
        chk("R1 reset rdata", reg_rdata, 8'h01);
        chk("R1 reset stb", cmd_stb_o, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // R2: busy flag and read-only bit 0
        busy_i = 1'b1;
        drv(8'h01);
        @(negedge clk);
        chk("R2 busy reads 0", reg_rdata[0], 1'b0);
        chk("R2 write bit0 no effect", reg_rdata, 8'h00);
        @(posedge clk); #1;
        busy_i = 1'b0;

        // R9: command while mode off is dropped
        cmd(16'h0010, 16'hBEEF);
        @(negedge clk);
        chk("R9 no strobe mode off", cmd_stb_o, 1'b0);
        @(posedge clk); #1;

        // R6 R7: gated bits before rewrite mode
        drv(8'h00); drv(8'h04);
        drv(8'h08);
        @(negedge clk);
        chk("R6 ovr ignored mode off", lock_ovr_o, 1'b0);
        chk("R7 frst ignored mode off", flash_rst_o, 1'b0);
        @(posedge clk); #1;

        // R3: NMI low blocks the sequence
        nmi_i = 1'b0;
        drv(8'h00); drv(8'h02);
        @(negedge clk);
        chk("R3 nmi low", rewrite_o, 1'b0);
        @(posedge clk); #1;
        nmi_i = 1'b1;

        // R5: gap breaks the sequence
        drv(8'h00); idle(1); drv(8'h02);
        @(negedge clk);
        chk("R5 gap", rewrite_o, 1'b0);
        @(posedge clk); #1;

        // R5: different value breaks the sequence
        drv(8'h00); drv(8'h0A);
        @(negedge clk);
        chk("R5 other bit differs", rewrite_o, 1'b0);
        @(posedge clk); #1;

        // R3: proper sequence
        drv(8'h00); drv(8'h02);
        @(negedge clk);
        chk("R3 enter rewrite", rewrite_o, 1'b1);
        chk("R11 readback", reg_rdata, 8'h03);
        @(posedge clk); #1;

        // R9: odd then even command
        cmd(16'h0021, 16'h1111);
        @(negedge clk);
        chk("R9 odd dropped", cmd_stb_o, 1'b0);
        @(posedge clk); #1;
        cmd(16'h0040, 16'h2222);
        @(negedge clk);
        chk("R9 even strobe", cmd_stb_o, 1'b1);
        chk("R9 even addr", cmd_addr_o, 16'h0040);
        chk("R9 even data", cmd_data_o, 16'h2222);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R9 strobe one cycle", cmd_stb_o, 1'b0);
        @(posedge clk); #1;

        // R6 R10: lock override
        erase_lock_i = 1'b0;
        drv(8'h02); drv(8'h06);
        @(negedge clk);
        chk("R6 ovr set", lock_ovr_o, 1'b1);
        chk("R10 locked block unlocked", erase_lock_o, 1'b1);
        @(posedge clk); #1;

        // R7: flash reset in rewrite mode
        drv(8'h0E);
        @(negedge clk);
        chk("R7 frst set", flash_rst_o, 1'b1);
        @(posedge clk); #1;
        drv(8'h06);
        @(negedge clk);
        chk("R7 frst released", flash_rst_o, 1'b0);
        @(posedge clk); #1;

        // R8: area select
        boot_i = 1'b1;
        drv(8'h26);
        @(negedge clk);
        chk("R8 boot user", user_area_o, 1'b1);
        @(posedge clk); #1;
        drv(8'h06);
        @(negedge clk);
        chk("R8 boot area", user_area_o, 1'b0);
        @(posedge clk); #1;
        boot_i = 1'b0;
        @(negedge clk);
        chk("R8 no boot", user_area_o, 1'b1);
        @(posedge clk); #1;

        // R4: leaving rewrite mode drops override
        drv(8'h04);
        @(negedge clk);
        chk("R4 rewrite cleared", rewrite_o, 1'b0);
        chk("R4 ovr cleared", lock_ovr_o, 1'b0);
        @(posedge clk); #1;

        // R8: bit 5 written outside rewrite mode
        boot_i = 1'b1;
        drv(8'h20);
        @(negedge clk);
        chk("R8 usel mode off", user_area_o, 1'b1);
        @(posedge clk); #1;
        erase_lock_i = 1'b1;
        idle(4);
        finish_run();
    end
endmodule